// File: doc/BRIEF.md
# Receive FIFO Interrupt Controller

This block is the receive-side interrupt logic of a 16550-compatible serial port. It takes characters from the receive deserialiser, stores them in a 16-entry FIFO together with their error flags, and presents the oldest entry to the CPU register interface. It reports a data-ready status and a line-status pending flag. It raises two kinds of receive interrupt. The data-available interrupt follows the FIFO fill level against a programmable trigger level. The character-timeout interrupt fires when characters sit in the FIFO while the line and the CPU are both idle.

The timeout window is four character times. It is measured in ticks of the receive baud clock, which runs at 16 ticks per bit, so the window scales with the baud rate and with the programmed frame format. A priority encoder merges the line-status, data-available and timeout conditions into a four-bit identification code and a single interrupt line.

Top module: `rx_irq_ctrl`

## Requirements
- R1: The FIFO holds up to 16 characters and returns them in arrival order on `head_data`/`head_err`. A push while 16 characters are stored is dropped, leaves the contents unchanged and sets `ls_pending`. A pop while the FIFO is empty has no effect.
- R2: `trig_sel` selects the trigger level: 0→1, 1→4, 2→8, 3→14 characters. `rda_irq` is high while `fill_count` is at or above the level and low as soon as it falls below.
- R3: `iid` codes: 4'b0110 line status (highest), 4'b0100 data available, 4'b1100 character timeout, 4'b0001 nothing pending. When data available and timeout are both active, data available is shown. `irq` is high exactly when `iid` is not 4'b0001.
- R4: After reset `fill_count` is 0, `data_ready` is 0 and `iid` is 4'b0001. `data_ready` goes high when a character enters the FIFO and goes low only when the FIFO becomes empty.
- R5: The timeout condition is set only while the FIFO is non-empty and a full timeout window of baud ticks has passed since both the last accepted push and the last accepted pop.
- R6: Frame bits = 1 start + (5 + `data_bits_sel`) data + `parity_en` + (1 + `two_stop`) stop. The timeout window is 4 × 16 × frame bits baud ticks. The condition becomes visible on `cto_irq` in the cycle after the tick that completes the window.
- R7: Once the timeout is pending, an accepted pop clears it. A push does not clear it.
- R8: While no timeout is pending, an accepted push or pop restarts the window from zero.
- R9: With `fifo_en` low, the effective trigger level is 1 and the timeout timer is held cleared, so `cto_irq` stays low.
- R10: `rx_irq_en` low forces `rda_irq` and `cto_irq` low. `ls_irq_en` low removes line status from `iid`.
- R11: `ls_pending` is set by an accepted push whose `push_err` is non-zero, or by an overflowing push. It is cleared by `ls_read` and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_irq_en | input | 1 | Receive data / timeout interrupt enable |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| trig_sel | input | 2 | Trigger level select |
| data_bits_sel | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | Second stop bit present in frame |
| baud_tick | input | 1 | Receive baud tick, 16 per bit |
| push | input | 1 | Character arrives from deserialiser |
| push_data | input | DATA_W (8) | Received character |
| push_err | input | ERR_W (3) | Error flags of the character |
| pop | input | 1 | CPU reads one character |
| ls_read | input | 1 | CPU reads line status, clears pending flag |
| head_data | output | DATA_W (8) | Oldest stored character |
| head_err | output | ERR_W (3) | Error flags of oldest character |
| fill_count | output | CNT_W (5) | Number of stored characters |
| data_ready | output | 1 | At least one character available |
| ls_pending | output | 1 | Line-status condition pending |
| rda_irq | output | 1 | Data-available interrupt |
| cto_irq | output | 1 | Character-timeout interrupt |
| irq | output | 1 | Combined interrupt |
| iid | output | 4 | Prioritised interrupt identification |

## Verification
The bench builds the block with its defaults: an 8-bit data path, 3 error bits, a depth of 16, 16 ticks per bit and a four-character window. With these values the full FIFO and the overflow can be reached in 17 pushes. The longest window, 768 ticks for a 12-bit frame, and the shortest, 448 ticks for a 7-bit frame, are each short enough to cross exactly on the boundary tick. Random runs mix idle stretches that are longer and shorter than the window with bursts of pushes and pops, so restarts, pending timeouts and trigger crossings all occur many times.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

  localparam logic [3:0] IID_NONE = 4'b0001;
  localparam logic [3:0] IID_LS   = 4'b0110;
  localparam logic [3:0] IID_RDA  = 4'b0100;
  localparam logic [3:0] IID_CTO  = 4'b1100;

  localparam int MAX_FRAME_BITS = 12;

  // Trigger level in characters for each select code.
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Bits on the wire for one character including start, parity and stops.
  function automatic int frame_bits(input logic [1:0] dsel,
                                    input logic par,
                                    input logic stop2);
    return 7 + int'(dsel) + int'(par) + int'(stop2);
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    if (p == ADDR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int TICKS_PER_BIT = 16,
  parameter int WINDOW_CHARS  = 4,
  localparam int LIMIT_MAX = WINDOW_CHARS * TICKS_PER_BIT * rx_irq_pkg::MAX_FRAME_BITS,
  localparam int TW = $clog2(LIMIT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       has_data,
  input  logic       took_char,
  input  logic       cpu_read,
  input  logic       tick,
  input  logic [1:0] data_bits_sel,
  input  logic       parity_en,
  input  logic       two_stop,
  output logic       expired
);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  always_comb begin
    limit = TW'(WINDOW_CHARS * TICKS_PER_BIT *
                rx_irq_pkg::frame_bits(data_bits_sel, parity_en, two_stop));
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || !has_data || cpu_read) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (took_char) begin
      cnt <= '0;
    end else if (tick && !expired) begin
      if (cnt == limit - 1'b1) begin
        expired <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_irq_prio.sv
module rx_irq_prio (
  input  logic       ls_act,
  input  logic       rda_act,
  input  logic       cto_act,
  output logic [3:0] iid,
  output logic       irq
);
  import rx_irq_pkg::*;

  always_comb begin
    if (ls_act)       iid = IID_LS;
    else if (rda_act) iid = IID_RDA;
    else if (cto_act) iid = IID_CTO;
    else              iid = IID_NONE;
    irq = ls_act | rda_act | cto_act;
  end

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl #(
  parameter int DATA_W        = 8,
  parameter int ERR_W         = 3,
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int WINDOW_CHARS  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              rx_irq_en,
  input  logic              ls_irq_en,
  input  logic [1:0]        trig_sel,
  input  logic [1:0]        data_bits_sel,
  input  logic              parity_en,
  input  logic              two_stop,
  input  logic              baud_tick,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ERR_W-1:0]  push_err,
  input  logic              pop,
  input  logic              ls_read,
  output logic [DATA_W-1:0] head_data,
  output logic [ERR_W-1:0]  head_err,
  output logic [CNT_W-1:0]  fill_count,
  output logic              data_ready,
  output logic              ls_pending,
  output logic              rda_irq,
  output logic              cto_irq,
  output logic              irq,
  output logic [3:0]        iid
);
  import rx_irq_pkg::*;

  localparam int ENTRY_W = DATA_W + ERR_W;

  logic               full, empty;
  logic               push_ok, pop_ok, overflow;
  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   level;
  logic               timer_hit;

  assign push_ok  = push & ~full;
  assign pop_ok   = pop & ~empty;
  assign overflow = push & full;

  rx_fifo_store #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_ok),
    .wr_data ({push_err, push_data}),
    .rd_en   (pop_ok),
    .head    (head),
    .count   (fill_count),
    .full    (full),
    .empty   (empty)
  );

  assign head_data = head[DATA_W-1:0];
  assign head_err  = head[ENTRY_W-1:DATA_W];

  rx_char_timer #(.TICKS_PER_BIT(TICKS_PER_BIT), .WINDOW_CHARS(WINDOW_CHARS)) u_timer (
    .clk           (clk),
    .rst           (rst),
    .enable        (fifo_en),
    .has_data      (~empty),
    .took_char     (push_ok),
    .cpu_read      (pop_ok),
    .tick          (baud_tick),
    .data_bits_sel (data_bits_sel),
    .parity_en     (parity_en),
    .two_stop      (two_stop),
    .expired       (timer_hit)
  );

  // Data-ready flag: set on arrival, cleared when the last entry leaves.
  always_ff @(posedge clk) begin
    if (rst)                                              data_ready <= 1'b0;
    else if (push_ok)                                     data_ready <= 1'b1;
    else if (pop_ok && fill_count == CNT_W'(1))           data_ready <= 1'b0;
  end

  // Line-status pending flag.
  always_ff @(posedge clk) begin
    if (rst)                                   ls_pending <= 1'b0;
    else if ((push_ok && |push_err) || overflow) ls_pending <= 1'b1;
    else if (ls_read)                          ls_pending <= 1'b0;
  end

  assign level   = fifo_en ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1);
  assign rda_irq = rx_irq_en & (fill_count >= level);
  assign cto_irq = rx_irq_en & fifo_en & timer_hit;

  rx_irq_prio u_prio (
    .ls_act  (ls_irq_en & ls_pending),
    .rda_act (rda_irq),
    .cto_act (cto_irq),
    .iid     (iid),
    .irq     (irq)
  );

endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             rx_irq_en,
  input logic             ls_irq_en,
  input logic             baud_tick,
  input logic             pop,
  input logic             ls_read,
  input logic [CNT_W-1:0] fill_count,
  input logic             data_ready,
  input logic             ls_pending,
  input logic             rda_irq,
  input logic             cto_irq,
  input logic             irq,
  input logic [3:0]       iid
);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CNT_W'(DEPTH));

  assert_ready_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    data_ready == (fill_count != '0));

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (rst)
    !irq |-> iid == 4'b0001);

  assert_ls_first_R3: assert property (@(posedge clk) disable iff (rst)
    (ls_pending && ls_irq_en) |-> iid == 4'b0110);

  assert_cto_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    cto_irq |-> fill_count != '0);

  assert_cto_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cto_irq) && $stable(rx_irq_en) && $stable(fifo_en)) |-> $past(baud_tick));

  assert_cto_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (cto_irq && !pop) |=> (cto_irq || !rx_irq_en || !fifo_en));

  assert_nofifo_R9: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> !cto_irq);

  assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_irq_en |-> (!rda_irq && !cto_irq));

  assert_ls_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (ls_pending && !ls_read) |=> ls_pending);

endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_en    (fifo_en),
  .rx_irq_en  (rx_irq_en),
  .ls_irq_en  (ls_irq_en),
  .baud_tick  (baud_tick),
  .pop        (pop),
  .ls_read    (ls_read),
  .fill_count (fill_count),
  .data_ready (data_ready),
  .ls_pending (ls_pending),
  .rda_irq    (rda_irq),
  .cto_irq    (cto_irq),
  .irq        (irq),
  .iid        (iid)
);

// File: tb/rx_irq_ctrl_test.sv
module rx_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b1, rx_irq_en = 1'b1, ls_irq_en = 1'b1;
  logic [1:0] trig_sel = 2'd1, data_bits_sel = 2'd3;
  logic parity_en = 1'b1, two_stop = 1'b1;
  logic baud_tick = 1'b0, push = 1'b0, pop = 1'b0, ls_read = 1'b0;
  logic [7:0] push_data = '0;
  logic [2:0] push_err = '0;
  logic [7:0] head_data;
  logic [2:0] head_err;
  logic [4:0] fill_count;
  logic data_ready, ls_pending, rda_irq, cto_irq, irq;
  logic [3:0] iid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int q_data[$];
  int q_err[$];
  bit m_ls = 0;
  bit m_cto = 0;
  int m_cnt = 0;

  rx_irq_ctrl uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
    .ls_irq_en(ls_irq_en), .trig_sel(trig_sel), .data_bits_sel(data_bits_sel),
    .parity_en(parity_en), .two_stop(two_stop), .baud_tick(baud_tick),
    .push(push), .push_data(push_data), .push_err(push_err), .pop(pop),
    .ls_read(ls_read), .head_data(head_data), .head_err(head_err),
    .fill_count(fill_count), .data_ready(data_ready), .ls_pending(ls_pending),
    .rda_irq(rda_irq), .cto_irq(cto_irq), .irq(irq), .iid(iid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int lvl_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int window_ticks();
    return 4 * 16 * (1 + 5 + int'(data_bits_sel) + int'(parity_en) + 1 + int'(two_stop));
  endfunction

  function automatic bit exp_rda();
    return rx_irq_en && (q_data.size() >= (fifo_en ? lvl_of(trig_sel) : 1));
  endfunction

  function automatic bit exp_cto();
    return rx_irq_en && fifo_en && m_cto;
  endfunction

  function automatic int exp_iid();
    if (ls_irq_en && m_ls) return 4'b0110;
    if (exp_rda())         return 4'b0100;
    if (exp_cto())         return 4'b1100;
    return 4'b0001;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_compare();
    chk(fill_count == q_data.size(), "R1 fill_count", fill_count, q_data.size());
    chk(data_ready == (q_data.size() != 0), "R4 data_ready", data_ready, q_data.size() != 0);
    chk(ls_pending == m_ls, "R11 ls_pending", ls_pending, m_ls);
    chk(rda_irq == exp_rda(), "R2 rda_irq", rda_irq, exp_rda());
    chk(cto_irq == exp_cto(), "R5 cto_irq", cto_irq, exp_cto());
    chk(iid == exp_iid(), "R3 iid", iid, exp_iid());
    chk(irq == (exp_iid() != 4'b0001), "R3 irq", irq, exp_iid() != 4'b0001);
    if (q_data.size() > 0)
      chk(head_data == q_data[0] && head_err == q_err[0], "R1 head", head_data, q_data[0]);
  endtask

  // One clock cycle: drive at the falling edge, update model, sample after the rising edge.
  task automatic step(input bit p, input int d, input int e, input bit r,
                      input bit lr, input bit t);
    bit pok, rok, ovf;
    @(negedge clk);
    push = p; push_data = 8'(d); push_err = 3'(e);
    pop = r; ls_read = lr; baud_tick = t;
    pok = p && q_data.size() < 16;
    rok = r && q_data.size() > 0;
    ovf = p && q_data.size() == 16;
    if (!fifo_en || q_data.size() == 0 || rok) begin
      m_cnt = 0; m_cto = 0;
    end else if (pok) begin
      m_cnt = 0;
    end else if (t && !m_cto) begin
      if (m_cnt == window_ticks() - 1) begin m_cto = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if ((pok && e != 0) || ovf) m_ls = 1;
    else if (lr) m_ls = 0;
    if (rok) begin void'(q_data.pop_front()); void'(q_err.pop_front()); end
    if (pok) begin q_data.push_back(d & 8'hff); q_err.push_back(e & 3'h7); end
    @(posedge clk);
    #1;
    model_compare();
  endtask

  task automatic push_ch(input int d, input int e); step(1, d, e, 0, 0, 0); endtask
  task automatic pop_ch(); step(0, 0, 0, 1, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask
  task automatic drain();
    while (q_data.size() > 0) pop_ch();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R4 / R3: reset state
    chk(fill_count == 0, "R4 reset fill", fill_count, 0);
    chk(data_ready == 0, "R4 reset data_ready", data_ready, 0);
    chk(iid == 4'b0001 && !irq, "R3 reset iid", iid, 1);

    // R2: below trigger level 4
    push_ch(8'hA1, 0); push_ch(8'hA2, 0); push_ch(8'hA3, 0);
    chk(rda_irq == 0, "R2 below level", rda_irq, 0);
    chk(data_ready == 1, "R4 set on push", data_ready, 1);
    push_ch(8'hA4, 0);
    chk(rda_irq == 1 && iid == 4'b0100, "R2 at level", iid, 4'b0100);
    chk(head_data == 8'hA1, "R1 order head", head_data, 8'hA1);
    pop_ch();
    chk(rda_irq == 0 && head_data == 8'hA2, "R2 drop below level", rda_irq, 0);

    // R6 / R5: 12-bit frame, window 768 ticks
    ticks(767);
    chk(cto_irq == 0, "R6 one tick short", cto_irq, 0);
    ticks(1);
    chk(cto_irq == 1 && iid == 4'b1100, "R5 timeout raised", iid, 4'b1100);

    // R7: push keeps pending timeout; data available shown over it
    push_ch(8'hA5, 0);
    chk(cto_irq == 1, "R7 push keeps timeout", cto_irq, 1);
    chk(iid == 4'b0100, "R3 rda over cto", iid, 4'b0100);
    pop_ch();
    chk(cto_irq == 0, "R7 pop clears timeout", cto_irq, 0);

    // R8: pop restarts the window
    ticks(700);
    pop_ch();
    ticks(700);
    chk(cto_irq == 0, "R8 restart on pop", cto_irq, 0);
    ticks(68);
    chk(cto_irq == 1, "R8 full window after restart", cto_irq, 1);

    // R11 / R3: error character sets line status
    push_ch(8'h55, 3'b001);
    chk(ls_pending == 1 && iid == 4'b0110, "R11 error sets ls", iid, 4'b0110);
    step(0, 0, 0, 0, 1, 0);
    chk(ls_pending == 0, "R11 ls_read clears", ls_pending, 1);

    // R10: enable gating
    rx_irq_en = 1'b0;
    idle();
    chk(!rda_irq && !cto_irq && iid == 4'b0001, "R10 rx gate", iid, 4'b0001);
    rx_irq_en = 1'b1;
    idle();

    // R6: 7-bit frame, window 448 ticks
    drain();
    data_bits_sel = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
    push_ch(8'h11, 0);
    ticks(447);
    chk(cto_irq == 0, "R6 short frame early", cto_irq, 0);
    ticks(1);
    chk(cto_irq == 1, "R6 short frame expiry", cto_irq, 1);

    // R9: FIFO disabled
    drain();
    fifo_en = 1'b0;
    push_ch(8'h22, 0);
    chk(rda_irq == 1, "R9 level one", rda_irq, 1);
    ticks(1000);
    chk(cto_irq == 0, "R9 no timeout", cto_irq, 0);
    fifo_en = 1'b1;
    drain();

    // R1: overflow and order
    for (int i = 0; i < 17; i++) push_ch(i + 8'h30, 0);
    chk(fill_count == 16, "R1 full count", fill_count, 16);
    chk(ls_pending == 1, "R1 overflow flags ls", ls_pending, 1);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) begin
      chk(head_data == i + 8'h30, "R1 fifo order", head_data, i + 8'h30);
      pop_ch();
    end
    pop_ch();
    chk(fill_count == 0 && data_ready == 0, "R1 pop when empty", fill_count, 0);

    // R2: levels 14 and 8
    trig_sel = 2'd3;
    for (int i = 0; i < 13; i++) push_ch(i, 0);
    chk(rda_irq == 0, "R2 level 14 below", rda_irq, 0);
    push_ch(8'h99, 0);
    chk(rda_irq == 1, "R2 level 14 reached", rda_irq, 1);
    trig_sel = 2'd2;
    idle();
    chk(rda_irq == 1, "R2 level 8", rda_irq, 1);
    drain();

    // Random phase
    for (int n = 0; n < 150; n++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      if (kind == 0) begin
        trig_sel = 2'($urandom_range(0, 3));
        data_bits_sel = 2'($urandom_range(0, 3));
        parity_en = 1'($urandom_range(0, 1));
        two_stop = 1'($urandom_range(0, 1));
        ls_irq_en = 1'($urandom_range(0, 1));
        idle();
      end else if (kind <= 3) begin
        for (int k = 0; k < int'($urandom_range(1, 6)); k++)
          step(1, int'($urandom_range(0, 255)), ($urandom_range(0, 7) == 0) ? 1 : 0,
               1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
               1'($urandom_range(0, 1)));
      end else if (kind <= 5) begin
        for (int k = 0; k < int'($urandom_range(1, 6)); k++)
          step(0, 0, 0, 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else begin
        for (int k = 0; k < int'($urandom_range(10, 850)); k++)
          step(0, 0, 0, 0, 0, 1'($urandom_range(0, 3) != 0));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule